// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the target side of a three-wire serial register bus. It has an active-low enable, a serial clock and one data line, which is split here into an input, an output and an output-enable. The host lowers the enable and clocks in a 9-bit control word. For a write it then clocks in a 16-bit data word. For a read the target takes the bus after a half-cycle turnaround and shifts out a 16-bit word. The serial pins are sampled by the system clock through a synchronizer, so the serial clock must stay at least four system clocks in each phase.

The control word carries three fields, most significant bit first. Bits [8:6] are the device prefix and must be `101`. Bit [5] is the direction, where 1 is read and 0 is write. Bits [4:0] are the register field. A field value `f` names the full register address `{101, f}`.

The target holds a small window of registers.
- Field 0 is the command register (address 0xA0). Writing it launches a command toward the core.
- Fields 1 to 3 are argument registers (0xA1 to 0xA3). They latch values for the core.
- Fields 8 to 15 are read-only response words (0xA8 to 0xAF), supplied by the core.

After each frame, the host raises the enable and gives one more clock pulse before the next frame can start.

Top module: `tw_target`

## Requirements
- R1: After reset, `ser_doe`, `cmd_strobe`, `cmd_word` and `args_o` are all zero.
- R2: The control word is sampled on serial clock rising edges while enable is low, most significant bit first. Its layout is prefix[8:6], direction[5] (1 = read, 0 = write) and register field[4:0]. For a write, the next 16 rising edges carry the data word, most significant bit first.
- R3: A complete write to field k (k = 1..3) sets `args_o[16*(k-1) +: 16]` to the data word. A read of fields 1 to 3 returns the stored word.
- R4: A complete write to field 0 raises `cmd_strobe` for exactly one system clock, with `cmd_word` equal to the data word and `args_o` unchanged. A read of field 0 returns the last command word.
- R5: For a read, `ser_doe` stays low through the ninth rising edge. It rises at the following falling edge, with bit 15 on `ser_dout`. Each later rising edge moves to the next lower bit. `ser_doe` falls after the sixteenth rising edge of the data phase.
- R6: A read of field 8+j (j = 0..7) returns `resp_i[16*j +: 16]`.
- R7: A read of an unmapped field (4 to 7, or 16 to 31) returns 0x0000.
- R8: A write to a response field or an unmapped field changes neither `args_o` nor `cmd_word`, and raises no strobe.
- R9: A frame whose prefix is not `101` is ignored. No register changes, and `ser_doe` never rises.
- R10: Raising the enable before a write's 16th data bit discards that write. After any frame, the target needs enable high plus one full clock pulse before a new frame. Clock pulses while enable stays high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock |
| ser_en_n | input | 1 | Serial bus enable, active low |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_doe | output | 1 | Output enable for the data line driver |
| resp_i | input | 128 | Eight 16-bit response words, word j at [16j+15:16j] |
| cmd_strobe | output | 1 | One-cycle command launch pulse |
| cmd_word | output | 16 | Last command word written |
| args_o | output | 48 | Three argument words, argument k at [16(k-1)+15:16(k-1)] |

## Verification
A bit counter that drifts by one shows up within the same frame. Read data comes out shifted or misses its last bit. A write lands a shifted word in `args_o`, which is visible a few system clocks after the final data edge. A frame state that is not returned to idle by the enable-high tail pulse corrupts the next frame, so every table entry that follows a broken one fails as well. The per-bit sampling of `ser_doe` in each read catches a turnaround that opens a half cycle early or late, and a driver that is not released.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WDATA,
        ST_TURN,
        ST_RDATA,
        ST_HOLD,
        ST_TAIL_HI,
        ST_TAIL_LO
    } tw_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] level
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = pin;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign level = stage_q[STAGES-1];

endmodule

// File: rtl/tw_frame.sv
module tw_frame
    import tw_pkg::*;
#(
    parameter int               DATA_W = 16,
    parameter int               ADDR_W = 5,
    parameter int               PFX_W  = 3,
    parameter logic [PFX_W-1:0] PFX    = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              en_n,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output logic              doe
);

    localparam int CTRL_W = PFX_W + 1 + ADDR_W;
    localparam int CNT_W  = $clog2(DATA_W + CTRL_W + 1);
    localparam int DIR_B  = ADDR_W;

    typedef struct packed {
        tw_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] shreg;
        logic              sck_prev;
        logic              oe;
        logic              wr;
    } frame_t;

    frame_t q, d;

    logic              rise, fall;
    logic [CTRL_W-1:0] ctrl_nx;

    assign rise    = sck & ~q.sck_prev;
    assign fall    = ~sck & q.sck_prev;
    assign ctrl_nx = {q.ctrl[CTRL_W-2:0], din};

    always_comb begin
        d          = q;
        d.wr       = 1'b0;
        d.sck_prev = sck;
        if (en_n && q.st != ST_IDLE && q.st != ST_TAIL_HI && q.st != ST_TAIL_LO) begin
            d.st = ST_TAIL_HI;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!en_n) begin
                        d.st  = ST_CTRL;
                        d.cnt = '0;
                    end
                end
                ST_CTRL: begin
                    if (rise) begin
                        d.ctrl = ctrl_nx;
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(CTRL_W - 1)) begin
                            d.cnt = '0;
                            if (ctrl_nx[CTRL_W-1 -: PFX_W] != PFX) d.st = ST_HOLD;
                            else if (ctrl_nx[DIR_B])               d.st = ST_TURN;
                            else                                   d.st = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (rise) begin
                        d.shreg = {q.shreg[DATA_W-2:0], din};
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.wr = 1'b1;
                            d.st = ST_HOLD;
                        end
                    end
                end
                ST_TURN: begin
                    if (fall) begin
                        d.shreg = rd_data;
                        d.oe    = 1'b1;
                        d.cnt   = '0;
                        d.st    = ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (rise) begin
                        d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.oe = 1'b0;
                            d.st = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: ;
                ST_TAIL_HI: if (rise) d.st = ST_TAIL_LO;
                ST_TAIL_LO: if (fall) d.st = ST_IDLE;
                default:    d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, ctrl: '0, shreg: '0,
                           sck_prev: 1'b0, oe: 1'b0, wr: 1'b0};
        else        q <= d;
    end

    assign rd_addr = q.ctrl[ADDR_W-1:0];
    assign wr_addr = q.ctrl[ADDR_W-1:0];
    assign wr_data = q.shreg;
    assign wr_en   = q.wr;
    assign doe     = q.oe;
    assign dout    = q.oe & q.shreg[DATA_W-1];

    assert_drive_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> (q.ctrl[CTRL_W-1 -: PFX_W] == PFX && q.ctrl[DIR_B]));

    assert_release_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !doe);

    assert_write_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(q.st) == ST_WDATA && !q.ctrl[DIR_B]));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DATA_W));

endmodule

// File: rtl/tw_regs.sv
module tw_regs #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int N_ARG     = 3,
    parameter int RESP_BASE = 8,
    parameter int N_RESP    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [N_RESP*DATA_W-1:0] resp_i,
    output logic                     cmd_strobe,
    output logic [DATA_W-1:0]        cmd_word,
    output logic [N_ARG*DATA_W-1:0]  args_o
);

    typedef struct packed {
        logic [DATA_W-1:0]             cmd;
        logic [N_ARG-1:0][DATA_W-1:0]  args;
        logic                          stb;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (wr_en) begin
            if (wr_addr == '0) begin
                d.cmd = wr_data;
                d.stb = 1'b1;
            end
            for (int k = 0; k < N_ARG; k++) begin
                if (wr_addr == ADDR_W'(k + 1)) d.args[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = q.cmd;
        for (int k = 0; k < N_ARG; k++) begin
            if (rd_addr == ADDR_W'(k + 1)) rd_data = q.args[k];
        end
        for (int j = 0; j < N_RESP; j++) begin
            if (rd_addr == ADDR_W'(RESP_BASE + j)) rd_data = resp_i[j*DATA_W +: DATA_W];
        end
    end

    for (genvar k = 0; k < N_ARG; k++) begin : g_arg
        assign args_o[k*DATA_W +: DATA_W] = q.args[k];
    end

    assign cmd_strobe = q.stb;
    assign cmd_word   = q.cmd;

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(wr_en && wr_addr == '0));

    assert_args_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr >= ADDR_W'(1) && wr_addr <= ADDR_W'(N_ARG)) |=> $stable(args_o));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |-> $stable(cmd_word));

endmodule

// File: rtl/tw_target.sv
module tw_target #(
    parameter int               DATA_W      = 16,
    parameter int               ADDR_W      = 5,
    parameter int               PFX_W       = 3,
    parameter logic [PFX_W-1:0] PFX         = 3'b101,
    parameter int               N_ARG       = 3,
    parameter int               RESP_BASE   = 8,
    parameter int               N_RESP      = 8,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_en_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic                     ser_doe,
    input  logic [N_RESP*DATA_W-1:0] resp_i,
    output logic                     cmd_strobe,
    output logic [DATA_W-1:0]        cmd_word,
    output logic [N_ARG*DATA_W-1:0]  args_o
);

    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    tw_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({ser_clk, ser_en_n, ser_din}),
        .level (pins_s)
    );

    tw_frame #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PFX_W  (PFX_W),
        .PFX    (PFX)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (pins_s[2]),
        .en_n    (pins_s[1]),
        .din     (pins_s[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (ser_dout),
        .doe     (ser_doe)
    );

    tw_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .N_ARG     (N_ARG),
        .RESP_BASE (RESP_BASE),
        .N_RESP    (N_RESP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .resp_i     (resp_i),
        .cmd_strobe (cmd_strobe),
        .cmd_word   (cmd_word),
        .args_o     (args_o)
    );

endmodule

// File: tb/tb_tw_target.sv
module tb_tw_target;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;

    typedef struct packed {
        logic       rd;
        logic [2:0] pfx;
        logic [4:0] fld;
        logic [15:0] val;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'b101, 5'd1,  16'h1234},
        '{1'b0, 3'b101, 5'd2,  16'hABCD},
        '{1'b0, 3'b101, 5'd3,  16'h0F0F},
        '{1'b1, 3'b101, 5'd1,  16'h1234},
        '{1'b1, 3'b101, 5'd3,  16'h0F0F},
        '{1'b1, 3'b101, 5'd8,  16'hC000},
        '{1'b1, 3'b101, 5'd15, 16'hC777},
        '{1'b1, 3'b101, 5'd5,  16'h0000},
        '{1'b1, 3'b101, 5'd20, 16'h0000},
        '{1'b0, 3'b101, 5'd9,  16'h5555},
        '{1'b1, 3'b101, 5'd9,  16'hC111},
        '{1'b1, 3'b101, 5'd2,  16'hABCD}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_en_n = 1'b1;
    logic         ser_din = 1'b0;
    logic         ser_dout, ser_doe, cmd_strobe;
    logic [127:0] resp_i;
    logic [15:0]  cmd_word;
    logic [47:0]  args_o;

    int n_chk = 0;
    int n_fail = 0;
    int strobe_total = 0;
    int oe_total = 0;
    logic [15:0] last_cmd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_target dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
        .resp_i(resp_i), .cmd_strobe(cmd_strobe), .cmd_word(cmd_word),
        .args_o(args_o)
    );

    always_comb begin
        for (int j = 0; j < 8; j++) resp_i[j*16 +: 16] = 16'hC000 + 16'(j) * 16'h0111;
    end

    always @(posedge clk) begin
        if (cmd_strobe) begin
            strobe_total <= strobe_total + 1;
            last_cmd     <= cmd_word;
        end
        if (ser_doe) oe_total <= oe_total + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        wait_h();
        ser_clk = 1'b1;
        wait_h();
        ser_clk = 1'b0;
    endtask

    task automatic send_ctrl(input logic [2:0] pfx, input logic rd, input logic [4:0] fld);
        logic [8:0] w;
        w = {pfx, rd, fld};
        ser_en_n = 1'b0;
        wait_h();
        for (int i = 8; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic end_frame();
        wait_h();
        ser_en_n = 1'b1;
        wait_h();
        ser_clk = 1'b1;
        wait_h();
        ser_clk = 1'b0;
        wait_h();
    endtask

    task automatic do_write(input logic [2:0] pfx, input logic [4:0] fld,
                            input logic [15:0] data, input int nbits);
        send_ctrl(pfx, 1'b0, fld);
        for (int i = 15; i > 15 - nbits; i--) send_bit(data[i]);
        end_frame();
    endtask

    task automatic do_read(input logic [2:0] pfx, input logic [4:0] fld,
                           output logic [15:0] rdata, output logic early_oe,
                           output logic oe_all, output logic late_oe);
        send_ctrl(pfx, 1'b1, fld);
        early_oe = ser_doe;
        oe_all = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            wait_h();
            rdata[i] = ser_dout;
            oe_all   = oe_all & ser_doe;
            ser_clk  = 1'b1;
            wait_h();
            ser_clk  = 1'b0;
        end
        wait_h();
        late_oe = ser_doe;
        end_frame();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [47:0] args_m;
        logic [15:0] rd;
        logic        e_oe, a_oe, l_oe;
        int          s0, o0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 doe", 64'(ser_doe), 64'h0);
        chk("R1 strobe", 64'(cmd_strobe), 64'h0);
        chk("R1 cmd_word", 64'(cmd_word), 64'h0);
        chk("R1 args", 64'(args_o), 64'h0);

        // Table walk: R2 R3 R5 R6 R7 R8
        args_m = '0;
        for (int v = 0; v < NV; v++) begin
            s0 = strobe_total;
            if (!VEC[v].rd) begin
                do_write(VEC[v].pfx, VEC[v].fld, VEC[v].val, 16);
                if (VEC[v].fld >= 5'd1 && VEC[v].fld <= 5'd3)
                    args_m[16*(int'(VEC[v].fld)-1) +: 16] = VEC[v].val;
                chk($sformatf("R2/R3/R8 write vec%0d args", v), 64'(args_o), 64'(args_m));
                chk($sformatf("R8 write vec%0d no strobe", v), 64'(strobe_total - s0), 64'h0);
            end else begin
                do_read(VEC[v].pfx, VEC[v].fld, rd, e_oe, a_oe, l_oe);
                chk($sformatf("R3/R6/R7 read vec%0d data", v), 64'(rd), 64'(VEC[v].val));
                chk($sformatf("R5 read vec%0d oe shape", v), {61'h0, e_oe, a_oe, l_oe}, 64'h2);
            end
        end

        // R4 command launch
        s0 = strobe_total;
        do_write(3'b101, 5'd0, 16'h5A3C, 16);
        chk("R4 strobe count", 64'(strobe_total - s0), 64'h1);
        chk("R4 strobe cmd", 64'(last_cmd), 64'h5A3C);
        chk("R4 cmd_word", 64'(cmd_word), 64'h5A3C);
        chk("R4 args unchanged", 64'(args_o), 64'(args_m));
        do_read(3'b101, 5'd0, rd, e_oe, a_oe, l_oe);
        chk("R4 readback", 64'(rd), 64'h5A3C);

        // R8 unmapped write
        s0 = strobe_total;
        do_write(3'b101, 5'd6, 16'h7777, 16);
        chk("R8 unmapped args", 64'(args_o), 64'(args_m));
        chk("R8 unmapped cmd", 64'(cmd_word), 64'h5A3C);
        chk("R8 unmapped strobe", 64'(strobe_total - s0), 64'h0);

        // R9 wrong prefix
        s0 = strobe_total;
        o0 = oe_total;
        do_write(3'b100, 5'd1, 16'hFFFF, 16);
        do_write(3'b101 ^ 3'b111, 5'd0, 16'hEEEE, 16);
        chk("R9 bad prefix args", 64'(args_o), 64'(args_m));
        chk("R9 bad prefix strobe", 64'(strobe_total - s0), 64'h0);
        do_read(3'b011, 5'd8, rd, e_oe, a_oe, l_oe);
        chk("R9 bad prefix no drive", 64'(oe_total - o0), 64'h0);
        chk("R9 bad prefix dout", 64'(rd), 64'h0);

        // R10 abort mid write
        do_write(3'b101, 5'd2, 16'h9999, 10);
        chk("R10 aborted write", 64'(args_o), 64'(args_m));
        do_write(3'b101, 5'd2, 16'h2468, 16);
        args_m[31:16] = 16'h2468;
        chk("R10 recovery write", 64'(args_o), 64'(args_m));

        // R10 pulses with enable high
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        chk("R10 idle pulses args", 64'(args_o), 64'(args_m));
        do_read(3'b101, 5'd1, rd, e_oe, a_oe, l_oe);
        chk("R10 idle pulses read", 64'(rd), 64'h1234);
        chk("R10 idle pulses oe", {61'h0, e_oe, a_oe, l_oe}, 64'h2);

        finish_run();
    end

endmodule